// File: doc/BRIEF.md
# Sequential 32-by-16 Integer Divide Unit

This unit divides a 32-bit dividend by a 16-bit divisor, either as unsigned or as two's-complement signed values. It returns one 32-bit word with the remainder in the upper half and the quotient in the lower half. It also returns the four arithmetic flags, a divide-by-zero indication and a write enable for the destination. A single-cycle start pulse captures the operands. The unit stays busy for a number of clock cycles that follows a fixed cost model, then raises done for one cycle.

Inside, the unit runs a restoring divider on operand magnitudes. Next to it runs an engine that walks the unsigned cost model, one step per clock. A latency counter holds done back until the modelled cycle count is reached. A zero divisor and a quotient out of range are both found as soon as the operands are captured. These cases finish early, the write enable stays low, and the result word equals the original dividend, so the destination is left unchanged.

Top module: `div32x16_seq`

## Requirements
- R1: Unsigned mode (signed_mode=0) with a non-zero divisor and a quotient below 65536: result is {remainder[15:0], quotient[15:0]} of dividend/divisor, and wr_en is 1 in the done cycle.
- R2: Signed mode (signed_mode=1): the divisor is sign-extended from 16 bits. The quotient truncates toward zero and the remainder takes the sign of the dividend. Both are packed as in R1 in two's complement, with wr_en=1.
- R3: On a written result, flag_v=0 and flag_c=0. flag_n equals bit 15 of the quotient, and flag_z is 1 exactly when the 16-bit quotient is zero.
- R4: A zero divisor in either mode sets div_zero=1 and keeps wr_en=0. result equals the dividend, all four flags are 0, and done comes 4 cycles after start.
- R5: Unsigned overflow (quotient of 65536 or more) sets flag_v=1, flag_c=0, flag_n=0, flag_z=0 and wr_en=0. result equals the dividend, and done comes 6 cycles after start.
- R6: Signed overflow (quotient above 32767 or below -32768) behaves as in R5: flag_v=1, other flags 0, wr_en=0, result equals the dividend, latency 6.
- R7: Unsigned latency, counted as cycles from the start edge to the edge that raises done, is built as follows. Start at 6 and align the divisor as D = divisor<<16. Then make 15 passes on a 32-bit copy of the dividend. If bit 31 is 1, shift left, subtract D and add 4. Otherwise shift left; if the value is at least D, subtract D and add 6, else add 8.
- R8: Signed latency is 12, plus 2 for a negative dividend, plus 2 for each 1 in bits 14..0 of the quotient magnitude, plus 6. Then add 2 more for a negative divisor, or else 4 more if only the dividend is negative.
- R9: half_cycles equals twice the latency of the operation just finished, and is valid from the done cycle on.
- R10: busy is 1 from the cycle after an accepted start until done. done is a one-cycle pulse. A start while busy is 1 is ignored and does not change the running operation's result or latency.
- R11: After reset, busy, done, wr_en, div_zero and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; operands are captured with it |
| signed_mode | input | 1 | 1 selects signed division, 0 unsigned |
| dividend | input | 32 | Dividend, also the current destination value |
| divisor | input | 16 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Destination write enable, pulsed with done |
| result | output | 32 | {remainder, quotient}, or the dividend when not written |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag, always cleared |
| div_zero | output | 1 | Divide-by-zero indication |
| half_cycles | output | 10 | Duration of the last operation in half-cycles |

## Verification
Most internal faults reach the ports at the done cycle. A wrong remainder or quotient bit in the restoring engine shows up directly in result and flag_n/flag_z. A wrong branch in the cost engine shifts done by 2 or 4 cycles, and half_cycles moves with it. A faulty overflow screen shows up as early as cycle 6, where a written result appears where the dividend should be, or the reverse. The vectors cover both signs of each operand, the quotient limits on either side of the range, and zero divisors in both modes, so that each branch is exercised.

// File: rtl/div32_pkg.sv
package div32_pkg;
  localparam int unsigned CYC_ZERO         = 4;
  localparam int unsigned CYC_OVF          = 6;
  localparam int unsigned CYC_U_BASE       = 6;
  localparam int unsigned CYC_U_MSB        = 4;
  localparam int unsigned CYC_U_SUB        = 6;
  localparam int unsigned CYC_U_NOSUB      = 8;
  localparam int unsigned CYC_S_BASE       = 12;
  localparam int unsigned CYC_S_NEGDD      = 2;
  localparam int unsigned CYC_S_TAIL       = 6;
  localparam int unsigned CYC_S_NEGDV      = 2;
  localparam int unsigned CYC_S_NEGDD_ONLY = 4;
  localparam int unsigned CYC_S_QBIT       = 2;

  function automatic int unsigned cost_width(input int unsigned qw);
    return $clog2(CYC_U_NOSUB * qw + 32) + 1;
  endfunction

  typedef enum logic [1:0] {
    OUT_WRITE = 2'd0,
    OUT_ZERO  = 2'd1,
    OUT_OVF   = 2'd2
  } outcome_e;
endpackage

// File: rtl/div_prescreen.sv
module div_prescreen
  import div32_pkg::*;
#(
  parameter int unsigned QW = 16,
  parameter int unsigned CW = 9
) (
  input  logic            signed_mode,
  input  logic [2*QW-1:0] dividend,
  input  logic [QW-1:0]   divisor,
  output logic            is_zero,
  output logic            is_ovf,
  output logic            neg_q,
  output logic            neg_r,
  output logic [2*QW-1:0] mag_dd,
  output logic [QW-1:0]   mag_dv,
  output logic [CW-1:0]   fixed_cost
);
  localparam int unsigned DW = 2 * QW;

  logic          dd_neg, dv_neg, ovf_s, ovf_u;
  logic [DW:0]   lim_pos, lim_neg;

  assign dd_neg = signed_mode & dividend[DW-1];
  assign dv_neg = signed_mode & divisor[QW-1];
  assign neg_q  = dd_neg ^ dv_neg;
  assign neg_r  = dd_neg;

  assign mag_dd = dd_neg ? (~dividend + 1'b1) : dividend;
  assign mag_dv = dv_neg ? (~divisor + 1'b1) : divisor;

  // positive quotient limit: |q| >= 2^(QW-1); negative: |q| >= 2^(QW-1)+1
  assign lim_pos = {2'b00, mag_dv, {(QW-1){1'b0}}};
  assign lim_neg = lim_pos + {{(QW+1){1'b0}}, mag_dv};
  assign ovf_s   = {1'b0, mag_dd} >= (neg_q ? lim_neg : lim_pos);
  assign ovf_u   = dividend[DW-1:QW] >= divisor;

  assign is_zero = (divisor == '0);
  assign is_ovf  = !is_zero && (signed_mode ? ovf_s : ovf_u);

  always_comb begin
    if (is_zero) begin
      fixed_cost = CW'(CYC_ZERO);
    end else if (is_ovf) begin
      fixed_cost = CW'(CYC_OVF);
    end else if (signed_mode) begin
      fixed_cost = CW'(CYC_S_BASE + CYC_S_TAIL);
      if (dd_neg) fixed_cost = fixed_cost + CW'(CYC_S_NEGDD);
      if (dv_neg)      fixed_cost = fixed_cost + CW'(CYC_S_NEGDV);
      else if (dd_neg) fixed_cost = fixed_cost + CW'(CYC_S_NEGDD_ONLY);
    end else begin
      fixed_cost = CW'(CYC_U_BASE);
    end
  end
endmodule

// File: rtl/div_restoring.sv
module div_restoring
  import div32_pkg::*;
#(
  parameter int unsigned QW = 16,
  parameter int unsigned CW = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            load_ok,
  input  logic [2*QW-1:0] num,
  input  logic [QW-1:0]   den,
  output logic [QW-1:0]   quot,
  output logic [QW-1:0]   rem,
  output logic            fin,
  output logic [CW-1:0]   qcost
);
  localparam int unsigned SW = $clog2(QW + 1);

  logic [QW-1:0] rem_q, num_q, den_q;
  logic [SW-1:0] step;
  logic          running, ok_q;
  logic [QW:0]   trial, diff;
  logic          ge;

  assign trial = {rem_q, num_q[QW-1]};
  assign diff  = trial - {1'b0, den_q};
  assign ge    = trial >= {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q   <= '0;
      num_q   <= '0;
      den_q   <= '0;
      step    <= '0;
      running <= 1'b0;
      ok_q    <= 1'b0;
      qcost   <= '0;
    end else if (load) begin
      rem_q   <= num[2*QW-1:QW];
      num_q   <= num[QW-1:0];
      den_q   <= den;
      step    <= '0;
      running <= 1'b1;
      ok_q    <= load_ok;
      qcost   <= '0;
    end else if (running) begin
      rem_q <= ge ? diff[QW-1:0] : trial[QW-1:0];
      num_q <= {num_q[QW-2:0], ge};
      if (ge && step != '0) qcost <= qcost + CW'(CYC_S_QBIT);
      step <= step + 1'b1;
      if (step == SW'(QW - 1)) running <= 1'b0;
    end
  end

  assign quot = num_q;
  assign rem  = rem_q;
  assign fin  = !running && (step == SW'(QW));

  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (rst)
    fin && ok_q |-> rem_q < den_q) else $error("remainder not below divisor"); // R1

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    running && !load |=> step == $past(step) + 1'b1) else $error("step stalled"); // R1
endmodule

// File: rtl/div_cost_unsigned.sv
module div_cost_unsigned
  import div32_pkg::*;
#(
  parameter int unsigned QW = 16,
  parameter int unsigned CW = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [2*QW-1:0] dividend,
  input  logic [QW-1:0]   divisor,
  output logic [CW-1:0]   cost,
  output logic            fin
);
  localparam int unsigned DW = 2 * QW;
  localparam int unsigned SW = $clog2(QW + 1);

  logic [DW-1:0] work, align, shifted;
  logic [SW-1:0] cnt;
  logic          running;

  assign shifted = {work[DW-2:0], 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      work    <= '0;
      align   <= '0;
      cnt     <= '0;
      running <= 1'b0;
      cost    <= '0;
    end else if (load) begin
      work    <= dividend;
      align   <= {divisor, {QW{1'b0}}};
      cnt     <= '0;
      running <= 1'b1;
      cost    <= '0;
    end else if (running) begin
      if (work[DW-1]) begin
        work <= shifted - align;
        cost <= cost + CW'(CYC_U_MSB);
      end else if (shifted >= align) begin
        work <= shifted - align;
        cost <= cost + CW'(CYC_U_SUB);
      end else begin
        work <= shifted;
        cost <= cost + CW'(CYC_U_NOSUB);
      end
      cnt <= cnt + 1'b1;
      if (cnt == SW'(QW - 2)) running <= 1'b0;
    end
  end

  assign fin = !running && (cnt == SW'(QW - 1));

  AST_COST_BOUND: assert property (@(posedge clk) disable iff (rst)
    cost <= CW'(CYC_U_NOSUB * (QW - 1))) else $error("cost above bound"); // R7

  AST_STEP_COST: assert property (@(posedge clk) disable iff (rst)
    running && !load |=> (cost == $past(cost) + CW'(CYC_U_MSB)) ||
                         (cost == $past(cost) + CW'(CYC_U_SUB)) ||
                         (cost == $past(cost) + CW'(CYC_U_NOSUB)))
    else $error("illegal step cost"); // R7
endmodule

// File: rtl/div32x16_seq.sv
module div32x16_seq
  import div32_pkg::*;
#(
  parameter int unsigned QW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            signed_mode,
  input  logic [2*QW-1:0] dividend,
  input  logic [QW-1:0]   divisor,
  output logic            busy,
  output logic            done,
  output logic            wr_en,
  output logic [2*QW-1:0] result,
  output logic            flag_n,
  output logic            flag_z,
  output logic            flag_v,
  output logic            flag_c,
  output logic            div_zero,
  output logic [cost_width(QW):0] half_cycles
);
  localparam int unsigned DW = 2 * QW;
  localparam int unsigned CW = cost_width(QW);

  logic            accept;
  logic            ps_zero, ps_ovf, ps_negq, ps_negr;
  logic [DW-1:0]   ps_mag_dd;
  logic [QW-1:0]   ps_mag_dv;
  logic [CW-1:0]   ps_fixed;

  logic [QW-1:0]   core_q, core_r;
  logic            core_fin, model_fin;
  logic [CW-1:0]   core_cost, model_cost;

  logic            busy_q, smode_q, negq_q, negr_q;
  outcome_e        kind_q;
  logic [CW-1:0]   fixed_q, elapsed, total;
  logic [DW-1:0]   dd_q;
  logic            ready, finish;
  logic [QW-1:0]   q_fix, r_fix;

  assign accept = start && !busy_q;

  div_prescreen #(.QW(QW), .CW(CW)) u_screen (
    .signed_mode (signed_mode),
    .dividend    (dividend),
    .divisor     (divisor),
    .is_zero     (ps_zero),
    .is_ovf      (ps_ovf),
    .neg_q       (ps_negq),
    .neg_r       (ps_negr),
    .mag_dd      (ps_mag_dd),
    .mag_dv      (ps_mag_dv),
    .fixed_cost  (ps_fixed)
  );

  div_restoring #(.QW(QW), .CW(CW)) u_core (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .load_ok (!ps_zero && !ps_ovf),
    .num     (ps_mag_dd),
    .den     (ps_mag_dv),
    .quot    (core_q),
    .rem     (core_r),
    .fin     (core_fin),
    .qcost   (core_cost)
  );

  div_cost_unsigned #(.QW(QW), .CW(CW)) u_cost (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .dividend (dividend),
    .divisor  (divisor),
    .cost     (model_cost),
    .fin      (model_fin)
  );

  always_comb begin
    if (kind_q != OUT_WRITE) total = fixed_q;
    else if (smode_q)        total = fixed_q + core_cost;
    else                     total = fixed_q + model_cost;
  end

  assign ready  = (kind_q != OUT_WRITE) || (core_fin && (smode_q || model_fin));
  assign finish = busy_q && ready && ((elapsed + 1'b1) == total);

  assign q_fix = negq_q ? (~core_q + 1'b1) : core_q;
  assign r_fix = negr_q ? (~core_r + 1'b1) : core_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      smode_q     <= 1'b0;
      negq_q      <= 1'b0;
      negr_q      <= 1'b0;
      kind_q      <= OUT_WRITE;
      fixed_q     <= '0;
      elapsed     <= '0;
      dd_q        <= '0;
      done        <= 1'b0;
      wr_en       <= 1'b0;
      result      <= '0;
      flag_n      <= 1'b0;
      flag_z      <= 1'b0;
      flag_v      <= 1'b0;
      flag_c      <= 1'b0;
      div_zero    <= 1'b0;
      half_cycles <= '0;
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        smode_q <= signed_mode;
        negq_q  <= ps_negq;
        negr_q  <= ps_negr;
        kind_q  <= ps_zero ? OUT_ZERO : (ps_ovf ? OUT_OVF : OUT_WRITE);
        fixed_q <= ps_fixed;
        elapsed <= '0;
        dd_q    <= dividend;
      end else if (busy_q) begin
        elapsed <= elapsed + 1'b1;
        if (finish) begin
          busy_q      <= 1'b0;
          done        <= 1'b1;
          half_cycles <= {total, 1'b0};
          flag_c      <= 1'b0;
          unique case (kind_q)
            OUT_ZERO: begin
              result   <= dd_q;
              div_zero <= 1'b1;
              flag_v   <= 1'b0;
              flag_n   <= 1'b0;
              flag_z   <= 1'b0;
            end
            OUT_OVF: begin
              result   <= dd_q;
              div_zero <= 1'b0;
              flag_v   <= 1'b1;
              flag_n   <= 1'b0;
              flag_z   <= 1'b0;
            end
            default: begin
              result   <= {r_fix, q_fix};
              div_zero <= 1'b0;
              wr_en    <= 1'b1;
              flag_v   <= 1'b0;
              flag_n   <= q_fix[QW-1];
              flag_z   <= (q_fix == '0);
            end
          endcase
        end
      end
    end
  end

  assign busy = busy_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R10

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(start)) else $error("busy without start"); // R10

  AST_NO_WRITE_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    done && (flag_v || div_zero) |-> !wr_en) else $error("write on fault"); // R5

  AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    done |-> !flag_c) else $error("carry set"); // R3

  AST_HALF_EVEN: assert property (@(posedge clk) disable iff (rst)
    done |-> !half_cycles[0]) else $error("odd half-cycle count"); // R9

  AST_COMPUTE_IN_TIME: assert property (@(posedge clk) disable iff (rst)
    busy_q && ((elapsed + 1'b1) == total) |-> ready) else $error("latency below compute time"); // R8

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !busy_q && !done && !wr_en) else $error("not idle after reset"); // R11
endmodule

// File: tb/test_div32x16_seq.sv
module test_div32x16_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy, done, wr_en, flag_n, flag_z, flag_v, flag_c, div_zero;
  logic [31:0] result;
  logic [9:0]  half_cycles;

  int tests_run = 0;
  int tests_failed = 0;

  always #10 clk = ~clk;

  div32x16_seq i_div32x16_seq (
    .clk(clk), .rst(rst), .start(start), .signed_mode(signed_mode),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .wr_en(wr_en), .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_v(flag_v), .flag_c(flag_c), .div_zero(div_zero),
    .half_cycles(half_cycles)
  );

  typedef struct {
    bit          zero;
    bit          ovf;
    bit [31:0]   res;
    bit          n;
    bit          z;
    int          cyc;
  } exp_t;

  // {signed_mode, dividend, divisor}
  localparam bit [48:0] VEC [15] = '{
    {1'b0, 32'd100,        16'd7},
    {1'b0, 32'd5,          16'd9},
    {1'b0, 32'hFFFE_FFFF,  16'hFFFF},
    {1'b0, 32'h0001_0000,  16'd1},
    {1'b0, 32'd1234,       16'd0},
    {1'b0, 32'h1234_5678,  16'h1234},
    {1'b1, 32'd1000,       16'hFFF9},
    {1'b1, 32'hFFFF_FC18,  16'd7},
    {1'b1, 32'hFFFF_FC18,  16'hFFF9},
    {1'b1, 32'h0000_8000,  16'd1},
    {1'b1, 32'hFFFF_8000,  16'd1},
    {1'b1, 32'h8000_0000,  16'hFFFF},
    {1'b1, 32'hFFFF_FFFB,  16'd7},
    {1'b1, 32'd77,         16'd0},
    {1'b1, 32'h7FFF_FFFF,  16'h7FFF}
  };

  function automatic exp_t model(input bit sm, input bit [31:0] dd, input bit [15:0] dv);
    exp_t e;
    longint q, r, sdd, sdv, aq;
    e.zero = 0; e.ovf = 0; e.res = dd; e.n = 0; e.z = 0; e.cyc = 0;
    if (dv == 0) begin
      e.zero = 1; e.cyc = 4;
      return e;
    end
    if (!sm) begin
      q = longint'(dd) / longint'(dv);
      r = longint'(dd) % longint'(dv);
      if (q >= 65536) begin
        e.ovf = 1; e.cyc = 6;
        return e;
      end
      begin
        bit [31:0] m;
        bit [31:0] al;
        m = dd; al = {dv, 16'h0000}; e.cyc = 6;
        for (int i = 0; i < 15; i++) begin
          if (m[31]) begin
            m = (m << 1) - al; e.cyc += 4;
          end else begin
            m = m << 1;
            if (m >= al) begin m = m - al; e.cyc += 6; end
            else e.cyc += 8;
          end
        end
      end
    end else begin
      sdd = longint'($signed(dd));
      sdv = longint'($signed(dv));
      q = sdd / sdv;
      r = sdd % sdv;
      if (q > 32767 || q < -32768) begin
        e.ovf = 1; e.cyc = 6;
        return e;
      end
      aq = (q < 0) ? -q : q;
      e.cyc = 12 + ((sdd < 0) ? 2 : 0) + 6;
      for (int b = 0; b < 15; b++) if (aq[b]) e.cyc += 2;
      if (sdv < 0) e.cyc += 2;
      else if (sdd < 0) e.cyc += 4;
    end
    e.res = {r[15:0], q[15:0]};
    e.n = q[15];
    e.z = (q[15:0] == 16'h0);
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // drives one operation; returns latency in edges after the start edge (-1 on timeout)
  task automatic run_op(input bit sm, input bit [31:0] dd, input bit [15:0] dv,
                        input bit poke, output int lat);
    @(negedge clk);
    signed_mode = sm; dividend = dd; divisor = dv; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    for (int k = 1; k <= 400; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (poke && k == 3) begin
        signed_mode = ~sm; dividend = 32'h0000_0064; divisor = 16'h0003; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (poke && k == 2) chk(busy == 1'b1, "R10", "busy while running", busy, 1);
      if (done) begin lat = k; break; end
    end
    start = 1'b0;
    if (lat == 0) begin
      chk(1'b0, "R10", "watchdog waiting for done", 0, 1);
      lat = -1;
    end
  endtask

  task automatic check_vec(input bit sm, input bit [31:0] dd, input bit [15:0] dv,
                           input bit poke);
    exp_t e;
    int lat;
    string tag, ltag;
    e = model(sm, dd, dv);
    run_op(sm, dd, dv, poke, lat);
    if (e.zero)      begin tag = "R4"; ltag = "R4"; end
    else if (e.ovf)  begin tag = sm ? "R6" : "R5"; ltag = tag; end
    else             begin tag = sm ? "R2" : "R1"; ltag = sm ? "R8" : "R7"; end
    chk(lat == e.cyc, ltag, "latency", lat, e.cyc);
    chk(result == e.res, tag, "result", result, e.res);
    chk(wr_en == !(e.zero || e.ovf), tag, "wr_en", wr_en, !(e.zero || e.ovf));
    chk(div_zero == e.zero, "R4", "div_zero", div_zero, e.zero);
    chk(flag_v == e.ovf, e.zero ? "R4" : (e.ovf ? tag : "R3"), "flag_v", flag_v, e.ovf);
    chk(flag_c == 1'b0, "R3", "flag_c", flag_c, 0);
    chk(flag_n == e.n, e.zero || e.ovf ? tag : "R3", "flag_n", flag_n, e.n);
    chk(flag_z == e.z, e.zero || e.ovf ? tag : "R3", "flag_z", flag_z, e.z);
    chk(half_cycles == 10'(2 * e.cyc), "R9", "half_cycles", half_cycles, 2 * e.cyc);
    chk(busy == 1'b0, "R10", "busy low at done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0 && wr_en == 1'b0, "R10", "done single pulse", {done, wr_en}, 0);
  endtask

  initial begin
    #(20ns * 150000);
    tests_run++;
    tests_failed++;
    $display("FAIL R10 global watchdog expired: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(busy == 0 && done == 0 && wr_en == 0, "R11", "control idle", {busy, done, wr_en}, 0);
    chk(div_zero == 0 && flag_n == 0 && flag_z == 0 && flag_v == 0 && flag_c == 0,
        "R11", "flags clear", {div_zero, flag_n, flag_z, flag_v, flag_c}, 0);

    foreach (VEC[i]) begin
      check_vec(VEC[i][48], VEC[i][47:16], VEC[i][15:0], 1'b0);
    end

    // R10: a start while busy must not disturb the running unsigned divide
    check_vec(1'b0, 32'h0009_8765, 16'h00F1, 1'b1);
    // the poke must not leave a second operation behind
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R10", "ignored start left idle", {busy, done}, 0);

    // back-to-back after a fault: signed small quotient then unsigned overflow
    check_vec(1'b1, 32'hFFFF_FFF9, 16'hFFFE, 1'b0);
    check_vec(1'b0, 32'hFFFF_0000, 16'hFFFF, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule